// File: doc/BRIEF.md
# Streaming Point-to-Point FIFO Channel

This block is a one-way data path from a single producer to a single consumer. It has no arbitration, no addressing and no handshake beyond its own flags. The producer pushes a data word together with a one-bit control flag whenever the channel is not full. The consumer sees the oldest stored word and its flag on its outputs as soon as a data-available flag rises. It pops that word with a read strobe.

A build-time option selects the clocking. In shared mode both sides run on one clock and the pointers are compared directly. In independent mode each side has its own clock, and the pointers cross between domains in Gray code through a chain of synchronizer flops. Each instance is one channel. A system that needs several channels instantiates the block several times.

Top module: `strm_chan`

## Requirements
- R1: While `rst` is high, and right after it is released, `prod_full` and `cons_avail` are both low and the channel holds no words.
- R2: Words leave in the order they were written, and each word carries the control flag that was written with it. In shared mode, a push and a pop on the same edge with one word stored leave exactly the new word stored.
- R3: Whenever `cons_avail` is high, `cons_data` and `cons_ctl` show the oldest word and its flag without any read. They stay unchanged until a read pops them.
- R4: After 2**DEPTH_LOG2 accepted writes with no reads, `prod_full` is high. A write while `prod_full` is high is dropped and leaves the stored words unchanged.
- R5: A read while `cons_avail` is low has no effect. A later write and read still return the correct word.
- R6: In shared mode (`CLK_MODE` = CLK_SHARED), a write at one edge makes `cons_avail` high right after that edge. A read while full makes `prod_full` low right after the same edge.
- R7: In independent mode, the pointer copy sent across domains changes by at most one bit per edge. `cons_avail` rises within a bounded number of consumer edges after a write. `prod_full` falls within a bounded number of producer edges after a read. The channel never accepts more than 2**DEPTH_LOG2 unread words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prod_clk | input | 1 | Producer clock |
| cons_clk | input | 1 | Consumer clock; tie to `prod_clk` in shared mode |
| rst | input | 1 | Active-high reset, asserted asynchronously in both domains |
| prod_wr | input | 1 | Write strobe |
| prod_data | input | DATA_W | Word to store |
| prod_ctl | input | 1 | Control flag stored with the word |
| prod_full | output | 1 | No room for another word |
| cons_rd | input | 1 | Read strobe; pops the head word |
| cons_data | output | DATA_W | Head word (show-ahead) |
| cons_ctl | output | 1 | Control flag of the head word |
| cons_avail | output | 1 | At least one word can be read |

## Verification
The bench builds two channels. The first is an independent-clock channel 8 entries deep, with a 200 MHz producer and a slower, unrelated consumer clock. Filling it to the brim and then draining it moves every pointer through the synchronizers and checks the bounded latency of both flags. The second is a shared-clock channel 4 entries deep. Its small depth makes the full boundary cheap to reach, and its direct pointer compare allows exact, edge-by-edge checks of flag timing and of a push and pop on the same edge.

// File: rtl/strm_chan_pkg.sv
package strm_chan_pkg;

   typedef enum logic {
      CLK_SHARED      = 1'b0,
      CLK_INDEPENDENT = 1'b1
   } clk_mode_e;

   localparam int unsigned MIN_DEPTH_LOG2 = 2;
   localparam int unsigned MAX_DEPTH_LOG2 = 12;
   localparam int unsigned MIN_SYNC       = 2;

endpackage

// File: rtl/strm_chan_mem.sv
module strm_chan_mem #(
   parameter int unsigned WIDTH = 33,
   parameter int unsigned AW    = 4
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam int unsigned DEPTH = 2 ** AW;

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/strm_chan_sync.sv
module strm_chan_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/strm_chan_wside.sv
module strm_chan_wside #(
   parameter int unsigned AW = 4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr,
   input  logic [AW:0] peer_gray,
   output logic [AW:0] bin,
   output logic [AW:0] gray,
   output logic        full,
   output logic        we
);
   logic [AW:0] bin_nx;
   logic [AW:0] full_pat;

   // full when the write pointer is one lap ahead: top two Gray bits inverted
   assign full_pat = {~peer_gray[AW:AW-1], peer_gray[AW-2:0]};
   assign full     = (gray == full_pat);
   assign we       = wr & ~full;
   assign bin_nx   = bin + 1'b1;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bin  <= '0;
         gray <= '0;
      end else if (we) begin
         bin  <= bin_nx;
         gray <= bin_nx ^ (bin_nx >> 1);
      end
   end
endmodule

// File: rtl/strm_chan_rside.sv
module strm_chan_rside #(
   parameter int unsigned AW = 4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        rd,
   input  logic [AW:0] peer_gray,
   output logic [AW:0] bin,
   output logic [AW:0] gray,
   output logic        avail
);
   logic [AW:0] bin_nx;
   logic        re;

   assign avail  = (gray != peer_gray);
   assign re     = rd & avail;
   assign bin_nx = bin + 1'b1;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bin  <= '0;
         gray <= '0;
      end else if (re) begin
         bin  <= bin_nx;
         gray <= bin_nx ^ (bin_nx >> 1);
      end
   end
endmodule

// File: rtl/strm_chan.sv
module strm_chan
   import strm_chan_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH_LOG2  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter clk_mode_e   CLK_MODE    = CLK_INDEPENDENT
) (
   input  logic              prod_clk,
   input  logic              cons_clk,
   input  logic              rst,
   input  logic              prod_wr,
   input  logic [DATA_W-1:0] prod_data,
   input  logic              prod_ctl,
   output logic              prod_full,
   input  logic              cons_rd,
   output logic [DATA_W-1:0] cons_data,
   output logic              cons_ctl,
   output logic              cons_avail
);
   localparam int unsigned ENTRY_W = DATA_W + 1;
   localparam int unsigned PTR_W   = DEPTH_LOG2 + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("strm_chan: DATA_W must be at least 1");
   end
   if (DEPTH_LOG2 < MIN_DEPTH_LOG2 || DEPTH_LOG2 > MAX_DEPTH_LOG2) begin : g_bad_depth
      $error("strm_chan: DEPTH_LOG2 out of range");
   end
   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("strm_chan: SYNC_STAGES must be at least 2");
   end

   logic [PTR_W-1:0]   w_bin, w_gray, r_bin, r_gray;
   logic [PTR_W-1:0]   r_gray_w;   // read pointer seen by producer side
   logic [PTR_W-1:0]   w_gray_r;   // write pointer seen by consumer side
   logic               wr_en;
   logic [ENTRY_W-1:0] head;

   strm_chan_wside #(.AW(DEPTH_LOG2)) wside_i (
      .clk(prod_clk), .rst(rst), .wr(prod_wr), .peer_gray(r_gray_w),
      .bin(w_bin), .gray(w_gray), .full(prod_full), .we(wr_en)
   );

   strm_chan_rside #(.AW(DEPTH_LOG2)) rside_i (
      .clk(cons_clk), .rst(rst), .rd(cons_rd), .peer_gray(w_gray_r),
      .bin(r_bin), .gray(r_gray), .avail(cons_avail)
   );

   strm_chan_mem #(.WIDTH(ENTRY_W), .AW(DEPTH_LOG2)) mem_i (
      .wclk(prod_clk), .we(wr_en), .waddr(w_bin[DEPTH_LOG2-1:0]),
      .wdata({prod_ctl, prod_data}), .raddr(r_bin[DEPTH_LOG2-1:0]),
      .rdata(head)
   );

   if (CLK_MODE == CLK_INDEPENDENT) begin : g_xclk
      strm_chan_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) r2w_i (
         .clk(prod_clk), .rst(rst), .d(r_gray), .q(r_gray_w)
      );
      strm_chan_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) w2r_i (
         .clk(cons_clk), .rst(rst), .d(w_gray), .q(w_gray_r)
      );
   end else begin : g_shared
      assign r_gray_w = r_gray;
      assign w_gray_r = w_gray;
   end

   assign cons_data = head[DATA_W-1:0];
   assign cons_ctl  = head[DATA_W];
endmodule

// File: rtl/strm_chan_chk.sv
module strm_chan_chk #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 4
) (
   input logic          prod_clk,
   input logic          cons_clk,
   input logic          rst,
   input logic          prod_wr,
   input logic          prod_full,
   input logic          cons_rd,
   input logic          cons_avail,
   input logic [DW-1:0] cons_data,
   input logic          cons_ctl,
   input logic [AW:0]   w_bin,
   input logic [AW:0]   w_gray,
   input logic [AW:0]   r_bin,
   input logic [AW:0]   r_gray,
   input logic [AW:0]   r_gray_w,
   input logic [AW:0]   w_gray_r
);
   localparam logic [AW:0] CAP = (AW+1)'(2 ** AW);

   logic [AW:0] rq_bin, wq_bin;

   always_comb begin
      rq_bin[AW] = r_gray_w[AW];
      wq_bin[AW] = w_gray_r[AW];
      for (int i = AW - 1; i >= 0; i--) begin
         rq_bin[i] = rq_bin[i+1] ^ r_gray_w[i];
         wq_bin[i] = wq_bin[i+1] ^ w_gray_r[i];
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge prod_clk) disable iff (rst)
      (w_bin - rq_bin) <= CAP);                                       // R7
   AST_NO_UNDERFLOW: assert property (@(posedge cons_clk) disable iff (rst)
      (wq_bin - r_bin) <= CAP);                                       // R5
   AST_FULL_DROP: assert property (@(posedge prod_clk) disable iff (rst)
      prod_full && prod_wr |=> $stable(w_bin));                       // R4
   AST_EMPTY_DROP: assert property (@(posedge cons_clk) disable iff (rst)
      !cons_avail && cons_rd |=> $stable(r_bin));                     // R5
   AST_HEAD_HOLD: assert property (@(posedge cons_clk) disable iff (rst)
      cons_avail && !cons_rd |=> cons_avail && $stable({cons_ctl, cons_data})); // R3
   AST_WGRAY_STEP: assert property (@(posedge prod_clk) disable iff (rst)
      $countones(w_gray ^ $past(w_gray)) <= 1);                       // R7
   AST_RGRAY_STEP: assert property (@(posedge cons_clk) disable iff (rst)
      $countones(r_gray ^ $past(r_gray)) <= 1);                       // R7
endmodule

bind strm_chan strm_chan_chk #(.DW(DATA_W), .AW(DEPTH_LOG2)) chk_i (
   .prod_clk(prod_clk), .cons_clk(cons_clk), .rst(rst),
   .prod_wr(prod_wr), .prod_full(prod_full), .cons_rd(cons_rd),
   .cons_avail(cons_avail), .cons_data(cons_data), .cons_ctl(cons_ctl),
   .w_bin(w_bin), .w_gray(w_gray), .r_bin(r_bin), .r_gray(r_gray),
   .r_gray_w(r_gray_w), .w_gray_r(w_gray_r)
);

// File: tb/strm_chan_tb_top.sv
module strm_chan_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned A_LOG2 = 3;   // independent-clock channel, 8 deep
   localparam int unsigned S_LOG2 = 2;   // shared-clock channel, 4 deep
   localparam int unsigned A_DEPTH = 2 ** A_LOG2;
   localparam int unsigned S_DEPTH = 2 ** S_LOG2;

   logic pclk = 1'b0, cclk = 1'b0, rst = 1'b1;
   always #2.5 pclk = ~pclk;   // 200 MHz
   always #3.5 cclk = ~cclk;

   int n_chk = 0, n_err = 0;

   // independent-clock channel
   logic          a_wr = 1'b0, a_wc = 1'b0, a_rd = 1'b0;
   logic [DW-1:0] a_wd = '0;
   logic          a_full, a_rc, a_avail;
   logic [DW-1:0] a_rdat;

   strm_chan #(.DATA_W(DW), .DEPTH_LOG2(A_LOG2), .SYNC_STAGES(2),
               .CLK_MODE(strm_chan_pkg::CLK_INDEPENDENT)) dut_i (
      .prod_clk(pclk), .cons_clk(cclk), .rst(rst),
      .prod_wr(a_wr), .prod_data(a_wd), .prod_ctl(a_wc), .prod_full(a_full),
      .cons_rd(a_rd), .cons_data(a_rdat), .cons_ctl(a_rc), .cons_avail(a_avail)
   );

   // shared-clock channel
   logic          s_wr = 1'b0, s_wc = 1'b0, s_rd = 1'b0;
   logic [DW-1:0] s_wd = '0;
   logic          s_full, s_rc, s_avail;
   logic [DW-1:0] s_rdat;

   strm_chan #(.DATA_W(DW), .DEPTH_LOG2(S_LOG2), .SYNC_STAGES(2),
               .CLK_MODE(strm_chan_pkg::CLK_SHARED)) dut_s_i (
      .prod_clk(pclk), .cons_clk(pclk), .rst(rst),
      .prod_wr(s_wr), .prod_data(s_wd), .prod_ctl(s_wc), .prod_full(s_full),
      .cons_rd(s_rd), .cons_data(s_rdat), .cons_ctl(s_rc), .cons_avail(s_avail)
   );

   task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return 32'hA5C0_0000 + DW'(i * 3);
   endfunction

   // shared-channel helpers: drive on falling edges, sample there
   task automatic s_push(input logic [DW-1:0] d, input logic c);
      @(negedge pclk); s_wr = 1'b1; s_wd = d; s_wc = c;
      @(negedge pclk); s_wr = 1'b0;
   endtask

   task automatic s_pop(input string req, input logic [DW-1:0] d, input logic c);
      @(negedge pclk);
      chk(req, {s_avail, s_rc, s_rdat}, {1'b1, c, d});
      s_rd = 1'b1;
      @(negedge pclk); s_rd = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 full in reset",  {32'd0, a_full | s_full},   '0);
      chk("R1 avail in reset", {32'd0, a_avail | s_avail}, '0);
      repeat (3) @(negedge cclk);
      rst = 1'b0;
      repeat (2) @(negedge pclk);
      chk("R1 flags after reset", {31'd0, a_full | s_full, a_avail | s_avail}, '0);
   endtask

   task automatic t_show_ahead;
      s_push(pat(1), 1'b1);
      // R6: word visible right after the write edge
      chk("R6 avail after write", {32'd0, s_avail}, 33'd1);
      chk("R3 head shown", {s_rc, s_rdat}, {1'b1, pat(1)});
      repeat (3) @(negedge pclk);
      chk("R3 head held", {s_avail, s_rc, s_rdat}, {1'b1, 1'b1, pat(1)});
      s_pop("R3 pop", pat(1), 1'b1);
      chk("R3 empty after pop", {32'd0, s_avail}, 33'd0);
   endtask

   task automatic t_order;
      for (int i = 10; i < 13; i++) s_push(pat(i), i[0]);
      for (int i = 10; i < 13; i++) s_pop("R2 order", pat(i), i[0]);
      chk("R2 drained", {32'd0, s_avail}, 33'd0);
      // push and pop on the same edge
      s_push(pat(20), 1'b0);
      @(negedge pclk);
      s_rd = 1'b1; s_wr = 1'b1; s_wd = pat(21); s_wc = 1'b1;
      @(negedge pclk);
      s_rd = 1'b0; s_wr = 1'b0;
      chk("R2 same-edge push/pop", {s_avail, s_rc, s_rdat}, {1'b1, 1'b1, pat(21)});
      s_pop("R2 same-edge result", pat(21), 1'b1);
      chk("R2 one word only", {32'd0, s_avail}, 33'd0);
   endtask

   task automatic t_full;
      for (int i = 0; i < S_DEPTH; i++) s_push(pat(30 + i), ~i[0]);
      chk("R4 full at depth", {32'd0, s_full}, 33'd1);
      s_push(32'hDEAD_BEEF, 1'b1);
      chk("R4 full after dropped write", {32'd0, s_full}, 33'd1);
      // R6: read while full frees a slot right after the same edge
      s_pop("R4 head intact", pat(30), 1'b1);
      chk("R6 full falls after read", {32'd0, s_full}, 33'd0);
      for (int i = 1; i < S_DEPTH; i++) s_pop("R4 stored words intact", pat(30 + i), ~i[0]);
      chk("R4 dropped word absent", {32'd0, s_avail}, 33'd0);
   endtask

   task automatic t_empty_read;
      @(negedge pclk); s_rd = 1'b1;
      repeat (2) @(negedge pclk);
      s_rd = 1'b0;
      chk("R5 still empty", {31'd0, s_avail, s_full}, 33'd0);
      s_push(pat(40), 1'b0);
      s_pop("R5 word after empty read", pat(40), 1'b0);
      chk("R5 empty again", {32'd0, s_avail}, 33'd0);
   endtask

   task automatic t_xclk;
      int waited;
      for (int i = 0; i < A_DEPTH; i++) begin
         @(negedge pclk); a_wr = 1'b1; a_wd = pat(50 + i); a_wc = i[1];
      end
      @(negedge pclk); a_wr = 1'b0;
      chk("R7 full at depth", {32'd0, a_full}, 33'd1);
      @(negedge pclk); a_wr = 1'b1; a_wd = 32'h0BAD_0BAD; a_wc = 1'b1;
      @(negedge pclk); a_wr = 1'b0;
      chk("R4 independent full holds", {32'd0, a_full}, 33'd1);
      for (int i = 0; i < A_DEPTH; i++) begin
         waited = 0;
         @(negedge cclk);
         while (!a_avail && waited < 6) begin
            @(negedge cclk); waited++;
         end
         chk("R7 word order across clocks", {a_avail, a_rc, a_rdat},
             {1'b1, i[1], pat(50 + i)});
         a_rd = 1'b1;
         @(negedge cclk); a_rd = 1'b0;
      end
      repeat (4) @(negedge cclk);
      chk("R7 nothing past depth", {32'd0, a_avail}, 33'd0);
      waited = 0;
      while (a_full && waited < 8) begin
         @(negedge pclk); waited++;
      end
      chk("R7 full falls in bound", {32'd0, a_full}, 33'd0);
      // single word latency into an empty channel
      @(negedge pclk); a_wr = 1'b1; a_wd = pat(70); a_wc = 1'b0;
      @(negedge pclk); a_wr = 1'b0;
      waited = 0;
      while (!a_avail && waited < 4) begin
         @(negedge cclk); waited++;
      end
      chk("R7 avail rises in bound", {a_avail, a_rc, a_rdat}, {1'b1, 1'b0, pat(70)});
      @(negedge cclk); a_rd = 1'b1;
      @(negedge cclk); a_rd = 1'b0;
      chk("R7 empty after last pop", {32'd0, a_avail}, 33'd0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_show_ahead();
            t_order();
            t_full();
            t_empty_read();
            t_xclk();
         end
         begin
            #1_000_000;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule